// File: doc/BRIEF.md
# Codec Register Access Sequencer

This block turns a single host request into the complete handshake needed to read or write one register of an audio codec. The codec is reached through the command register of a serial-link controller. A request carries a direction, a 7-bit register index and, for writes, a 16-bit value. The sequencer first clears the controller's command-done event. It then writes the command word and samples the done flag at fixed intervals until the flag is seen or a poll budget runs out. After each attempt it clears the event again.

A read counts as good only when the register index echoed in the response matches the index that was asked for. A write counts as good as soon as the done flag is seen. A failed attempt is repeated until a fixed number of attempts has been used. The host then gets one done pulse and a 16-bit result. A good read returns its data, a good write returns zero, and an exhausted request returns all ones. The poll interval is a parameter counted in clock cycles, which lets a fast test use short intervals.

Top module: `codec_reg_seq`

## Requirements
- R1: A request on `req_valid` is taken only while `busy` is low. `busy` rises in the cycle after acceptance and stays high through the cycle in which `done` is high. A request raised while `busy` is high is ignored and starts no later transaction.
- R2: `evt_clr` pulses once before the first command of a request and once after each attempt, so a request with N attempts gives N+1 clear pulses. The first clear comes before the first `cmd_valid`.
- R3: Command word layout. Bit 25 is the read flag (1 = read). Bits 22:16 hold the register index. Bits 15:0 hold the write value for a write and zero for a read. All other bits are zero.
- R4: Within an attempt, `evt_done` is sampled once every POLL_GAP_CYC cycles, counted from the cycle after the command. The attempt ends at the first sample that finds the flag high, or after POLL_LIMIT samples without it.
- R5: For a read, the index in bits 22:16 of `codec_resp` is captured together with bits 15:0 at the sample that sees the done flag. If that index differs from the requested index, the attempt fails and is retried.
- R6: A request makes at most MAX_TRIES attempts in total. Each attempt issues exactly one `cmd_valid` pulse.
- R7: A read that succeeds returns bits 15:0 of the matching response. A read whose attempts all fail returns 16'hFFFF.
- R8: A write ignores the echoed index and retries only on a poll timeout. It returns 16'h0000 on success and 16'hFFFF once all attempts have timed out.
- R9: `done` is a single-cycle pulse. `rdata` changes only in the cycle in which `done` is high and holds its value until the next `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_index | input | 7 | Codec register index |
| req_wdata | input | 16 | Write value |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Result of the last request |
| cmd_valid | output | 1 | Write strobe for the controller command register |
| cmd_word | output | 26 | Command word |
| evt_clr | output | 1 | Write-one-to-clear of the command-done event |
| evt_done | input | 1 | Command-done event flag |
| codec_resp | input | 23 | Response word: echoed index in 22:16, data in 15:0 |

## Verification
The embedded assertions check several rules on every cycle. They check the acceptance handshake, that `done` is a lone pulse inside the busy window, and that `rdata` moves only with `done`. They also check that every request opens with a clear pulse, that the poll count never passes its limit, and that the attempt counter never passes its bound. Only the bench scenarios can show the things that depend on what the controller answers. These are the retry counts for mismatched echoes and for timeouts, the all-ones result after exhaustion, a write accepting a wrong echo, and the exact length of a fully timed-out request. The bench observes all of these through a controller model that can stay silent or echo a wrong index for a chosen number of commands.

// File: rtl/crs_pkg.sv
package crs_pkg;

  localparam int IDX_W   = 7;
  localparam int DATA_W  = 16;
  localparam int IDX_LSB = 16;
  localparam int RD_BIT  = 25;
  localparam int CMD_W   = RD_BIT + 1;
  localparam int RESP_W  = IDX_LSB + IDX_W;

  typedef enum logic [2:0] {
    S_IDLE,
    S_CLR_PRE,
    S_ISSUE,
    S_WAIT,
    S_CLR_POST,
    S_DONE
  } seq_state_t;

  function automatic logic [CMD_W-1:0] build_cmd(
    input logic              rd,
    input logic [IDX_W-1:0]  idx,
    input logic [DATA_W-1:0] val
  );
    logic [CMD_W-1:0] w;
    w = '0;
    w[RD_BIT] = rd;
    w[IDX_LSB +: IDX_W] = idx;
    if (!rd) w[DATA_W-1:0] = val;
    return w;
  endfunction

endpackage

// File: rtl/crs_poll_timer.sv
module crs_poll_timer #(
  parameter int GAP   = 2100,
  parameter int LIMIT = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic run,
  output logic tick,
  output logic last_poll
);

  localparam int GW = (GAP > 1) ? $clog2(GAP) : 1;
  localparam int LW = $clog2(LIMIT + 1);

  logic [GW-1:0] gap_q, gap_d;
  logic [LW-1:0] poll_q, poll_d;
  logic          gap_end;

  assign gap_end   = (gap_q == GW'(GAP - 1));
  assign tick      = run && gap_end;
  assign last_poll = (poll_q == LW'(LIMIT - 1));

  always_comb begin
    gap_d  = gap_q;
    poll_d = poll_q;
    if (restart) begin
      gap_d  = '0;
      poll_d = '0;
    end else if (run) begin
      if (gap_end) begin
        gap_d  = '0;
        poll_d = poll_q + LW'(1);
      end else begin
        gap_d = gap_q + GW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q  <= '0;
      poll_q <= '0;
    end else if (restart || run) begin
      gap_q  <= gap_d;
      poll_q <= poll_d;
    end
  end

  // R4: while waiting, no more than LIMIT samples are ever counted
  a_r4_poll_bound: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (poll_q <= LW'(LIMIT - 1)));

endmodule

// File: rtl/crs_try_counter.sv
module crs_try_counter #(
  parameter int MAX = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic step,
  output logic last_try
);

  localparam int TW = $clog2(MAX + 1);

  logic [TW-1:0] cnt_q, cnt_d;

  assign last_try = (cnt_q == TW'(MAX - 1));

  always_comb begin
    cnt_d = cnt_q;
    if (clear)     cnt_d = '0;
    else if (step) cnt_d = cnt_q + TW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (clear || step)  cnt_q <= cnt_d;
  end

  // R6: the attempt index never goes past the last allowed attempt
  a_r6_try_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= TW'(MAX - 1));

endmodule

// File: rtl/crs_resp_check.sv
module crs_resp_check
  import crs_pkg::*;
(
  input  logic              is_read,
  input  logic              hit,
  input  logic [IDX_W-1:0]  want_idx,
  input  logic [IDX_W-1:0]  echo_idx,
  input  logic [DATA_W-1:0] echo_data,
  output logic              pass,
  output logic [DATA_W-1:0] pass_data
);

  logic idx_ok;

  assign idx_ok    = (echo_idx == want_idx);
  assign pass      = hit && (!is_read || idx_ok);
  assign pass_data = is_read ? echo_data : '0;

endmodule

// File: rtl/codec_reg_seq.sv
module codec_reg_seq
  import crs_pkg::*;
#(
  parameter int POLL_GAP_CYC = 2100,
  parameter int POLL_LIMIT   = 20,
  parameter int MAX_TRIES    = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [IDX_W-1:0]  req_index,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic              cmd_valid,
  output logic [CMD_W-1:0]  cmd_word,
  output logic              evt_clr,
  input  logic              evt_done,
  input  logic [RESP_W-1:0] codec_resp
);

  seq_state_t        state_q, state_d;
  logic              rd_q, rd_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [DATA_W-1:0] wdat_q, wdat_d;
  logic              hit_q, hit_d;
  logic [IDX_W-1:0]  eidx_q, eidx_d;
  logic [DATA_W-1:0] edat_q, edat_d;
  logic [DATA_W-1:0] out_q, out_d;

  logic tick, last_poll, last_try, pass;
  logic [DATA_W-1:0] pass_data;
  logic try_clear, try_step, tmr_restart, tmr_run;

  crs_poll_timer #(.GAP(POLL_GAP_CYC), .LIMIT(POLL_LIMIT)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart   (tmr_restart),
    .run       (tmr_run),
    .tick      (tick),
    .last_poll (last_poll)
  );

  crs_try_counter #(.MAX(MAX_TRIES)) u_tries (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (try_clear),
    .step     (try_step),
    .last_try (last_try)
  );

  crs_resp_check u_check (
    .is_read   (rd_q),
    .hit       (hit_q),
    .want_idx  (idx_q),
    .echo_idx  (eidx_q),
    .echo_data (edat_q),
    .pass      (pass),
    .pass_data (pass_data)
  );

  assign tmr_restart = (state_q == S_ISSUE);
  assign tmr_run     = (state_q == S_WAIT);
  assign try_clear   = (state_q == S_IDLE);
  assign try_step    = (state_q == S_CLR_POST) && !pass && !last_try;

  always_comb begin
    state_d = state_q;
    rd_d    = rd_q;
    idx_d   = idx_q;
    wdat_d  = wdat_q;
    hit_d   = hit_q;
    eidx_d  = eidx_q;
    edat_d  = edat_q;
    out_d   = out_q;
    unique case (state_q)
      S_IDLE: begin
        if (req_valid) begin
          state_d = S_CLR_PRE;
          rd_d    = !req_write;
          idx_d   = req_index;
          wdat_d  = req_wdata;
        end
      end
      S_CLR_PRE: state_d = S_ISSUE;
      S_ISSUE: begin
        hit_d   = 1'b0;
        state_d = S_WAIT;
      end
      S_WAIT: begin
        if (tick && evt_done) begin
          hit_d   = 1'b1;
          eidx_d  = codec_resp[IDX_LSB +: IDX_W];
          edat_d  = codec_resp[DATA_W-1:0];
          state_d = S_CLR_POST;
        end else if (tick && last_poll) begin
          state_d = S_CLR_POST;
        end
      end
      S_CLR_POST: begin
        if (pass) begin
          out_d   = pass_data;
          state_d = S_DONE;
        end else if (last_try) begin
          out_d   = '1;
          state_d = S_DONE;
        end else begin
          state_d = S_ISSUE;
        end
      end
      S_DONE:  state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      rd_q    <= 1'b0;
      idx_q   <= '0;
      wdat_q  <= '0;
      hit_q   <= 1'b0;
      eidx_q  <= '0;
      edat_q  <= '0;
      out_q   <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == S_IDLE) begin
        rd_q   <= rd_d;
        idx_q  <= idx_d;
        wdat_q <= wdat_d;
      end
      if (state_q == S_ISSUE || state_q == S_WAIT) begin
        hit_q  <= hit_d;
        eidx_q <= eidx_d;
        edat_q <= edat_d;
      end
      if (state_q == S_CLR_POST) out_q <= out_d;
    end
  end

  assign busy      = (state_q != S_IDLE);
  assign done      = (state_q == S_DONE);
  assign rdata     = out_q;
  assign evt_clr   = (state_q == S_CLR_PRE) || (state_q == S_CLR_POST);
  assign cmd_valid = (state_q == S_ISSUE);
  assign cmd_word  = build_cmd(rd_q, idx_q, wdat_q);

  // R1: an idle request is taken on the next edge
  a_r1_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy) |=> busy);

  // R1: completion is signalled inside the busy window
  a_r1_done_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);

  // R2: a request opens with a clear, never with a command
  a_r2_clear_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (evt_clr && !cmd_valid));

  // R2: clear and command strobes never coincide
  a_r2_strobes_apart: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({evt_clr, cmd_valid}));

  // R9: completion lasts one cycle
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9: result changes only together with the completion pulse
  a_r9_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rdata) |-> done);

endmodule

// File: tb/codec_reg_seq_test.sv
module codec_reg_seq_test;

  localparam int GAP   = 4;
  localparam int LIMIT = 20;
  localparam int TRIES = 5;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write;
  logic [6:0]  req_index;
  logic [15:0] req_wdata;
  logic        busy, done, cmd_valid, evt_clr;
  logic [15:0] rdata;
  logic [25:0] cmd_word;
  logic        evt_done;
  logic [22:0] codec_resp;

  always #2 clk = ~clk;

  codec_reg_seq #(.POLL_GAP_CYC(GAP), .POLL_LIMIT(LIMIT), .MAX_TRIES(TRIES)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_index(req_index), .req_wdata(req_wdata), .busy(busy), .done(done),
    .rdata(rdata), .cmd_valid(cmd_valid), .cmd_word(cmd_word), .evt_clr(evt_clr),
    .evt_done(evt_done), .codec_resp(codec_resp)
  );

  int n_chk = 0;
  int n_bad = 0;

  // controller model
  int        m_lat = 10;
  int        m_silent = 0;
  int        m_bad = 0;
  bit        m_pend = 0;
  int        m_cnt = 0;
  logic [6:0] m_idx = '0;
  logic       m_flag = 1'b0;
  logic [22:0] m_resp = '0;

  assign evt_done   = m_flag;
  assign codec_resp = m_resp;

  always @(negedge clk) begin
    if (evt_clr) m_flag = 1'b0;
    if (cmd_valid) begin
      if (m_silent > 0) m_silent--;
      else begin
        m_pend = 1;
        m_cnt  = m_lat;
        m_idx  = cmd_word[22:16];
      end
    end else if (m_pend) begin
      if (m_cnt == 0) begin
        m_flag = 1'b1;
        m_resp = {(m_bad > 0) ? (m_idx ^ 7'h01) : m_idx, m_idx, 9'h0A5};
        if (m_bad > 0) m_bad--;
        m_pend = 0;
      end else m_cnt--;
    end
  end

  // monitor
  bit          mon_on = 0;
  logic [6:0]  mon_idx;
  int          n_cmd, n_clr, n_busy, n_done, n_foreign;
  bit          clr_first;
  logic [25:0] last_word;

  always @(negedge clk) begin
    if (mon_on) begin
      if (evt_clr && n_cmd == 0 && n_clr == 0) clr_first = 1;
      if (cmd_valid) begin
        n_cmd++;
        last_word = cmd_word;
        if (cmd_word[22:16] != mon_idx) n_foreign++;
      end
      if (evt_clr) n_clr++;
      if (busy) n_busy++;
      if (done) n_done++;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic start_txn(input logic wr, input logic [6:0] idx, input logic [15:0] val);
    n_cmd = 0; n_clr = 0; n_busy = 0; n_done = 0; n_foreign = 0;
    clr_first = 0; mon_idx = idx; mon_on = 1;
    req_valid = 1'b1; req_write = wr; req_index = idx; req_wdata = val;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_done(output logic [15:0] res);
    int guard;
    guard = 0;
    res = 'x;
    while (guard < 3000) begin
      @(negedge clk);
      guard++;
      if (done) begin
        res = rdata;
        break;
      end
    end
    if (guard >= 3000) check("watchdog transaction", 32'd0, 32'd1);
    @(negedge clk);
    mon_on = 0;
  endtask

  task automatic t_reset;
    check("R1 reset busy", {31'd0, busy}, 32'd0);
    check("R9 reset done", {31'd0, done}, 32'd0);
    check("R9 reset rdata", {16'd0, rdata}, 32'd0);
    check("R2 reset evt_clr", {31'd0, evt_clr}, 32'd0);
    check("R6 reset cmd_valid", {31'd0, cmd_valid}, 32'd0);
  endtask

  task automatic t_write_ok;
    logic [15:0] r;
    m_lat = 10; m_silent = 0; m_bad = 0;
    start_txn(1'b1, 7'h2C, 16'hBEEF);
    wait_done(r);
    check("R8 write result", {16'd0, r}, 32'h0);
    check("R3 write word", {6'd0, last_word}, {6'd0, 26'h02CBEEF});
    check("R6 write attempts", n_cmd, 1);
    check("R2 clear count", n_clr, 2);
    check("R2 clear first", {31'd0, clr_first}, 32'd1);
    check("R4 busy length", n_busy, 16);
    check("R9 done once", n_done, 1);
  endtask

  task automatic t_read_ok;
    logic [15:0] r;
    m_lat = 3; m_silent = 0; m_bad = 0;
    start_txn(1'b0, 7'h7E, 16'h1234);
    wait_done(r);
    check("R7 read data", {16'd0, r}, {16'd0, 7'h7E, 9'h0A5});
    check("R3 read word", {6'd0, last_word}, {6'd0, 26'h27E0000});
    check("R6 read attempts", n_cmd, 1);
  endtask

  task automatic t_read_mismatch_recover;
    logic [15:0] r;
    m_lat = 5; m_silent = 0; m_bad = 2;
    start_txn(1'b0, 7'h10, 16'h0);
    wait_done(r);
    check("R5 retries on echo mismatch", n_cmd, 3);
    check("R2 clears per attempt", n_clr, 4);
    check("R7 data after retry", {16'd0, r}, {16'd0, 7'h10, 9'h0A5});
  endtask

  task automatic t_read_exhaust;
    logic [15:0] r;
    m_lat = 2; m_silent = 0; m_bad = 99;
    start_txn(1'b0, 7'h05, 16'h0);
    wait_done(r);
    check("R6 max attempts read", n_cmd, TRIES);
    check("R2 clears exhausted", n_clr, TRIES + 1);
    check("R7 exhausted read", {16'd0, r}, 32'h0000FFFF);
    m_bad = 0;
  endtask

  task automatic t_write_timeout_all;
    logic [15:0] r;
    m_lat = 2; m_silent = TRIES; m_bad = 0;
    start_txn(1'b1, 7'h11, 16'h5A5A);
    wait_done(r);
    check("R8 timeout result", {16'd0, r}, 32'h0000FFFF);
    check("R6 timeout attempts", n_cmd, TRIES);
    check("R4 full timeout length", n_busy, 2 + TRIES * (2 + LIMIT * GAP));
    m_silent = 0;
  endtask

  task automatic t_write_timeout_some;
    logic [15:0] r;
    m_lat = 4; m_silent = 2; m_bad = 0;
    start_txn(1'b1, 7'h22, 16'h0F0F);
    wait_done(r);
    check("R8 retry on timeout", n_cmd, 3);
    check("R8 recovered write", {16'd0, r}, 32'h0);
  endtask

  task automatic t_write_bad_echo;
    logic [15:0] r;
    m_lat = 4; m_silent = 0; m_bad = 1;
    start_txn(1'b1, 7'h30, 16'hAAAA);
    wait_done(r);
    check("R8 no index check on write", n_cmd, 1);
    check("R8 write result bad echo", {16'd0, r}, 32'h0);
    m_bad = 0;
  endtask

  task automatic t_read_silent_once;
    logic [15:0] r;
    m_lat = 6; m_silent = 1; m_bad = 0;
    start_txn(1'b0, 7'h44, 16'h0);
    wait_done(r);
    check("R5 read retry after timeout", n_cmd, 2);
    check("R7 read after timeout", {16'd0, r}, {16'd0, 7'h44, 9'h0A5});
  endtask

  task automatic t_busy_ignore;
    logic [15:0] r;
    bit late;
    m_lat = 8; m_silent = 0; m_bad = 0;
    start_txn(1'b0, 7'h0C, 16'h0);
    repeat (4) @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_index = 7'h33; req_wdata = 16'hDEAD;
    repeat (3) @(negedge clk);
    req_valid = 1'b0;
    wait_done(r);
    check("R1 busy request not issued", n_foreign, 0);
    check("R1 first request result", {16'd0, r}, {16'd0, 7'h0C, 9'h0A5});
    late = 0;
    repeat (6) begin
      @(negedge clk);
      if (busy) late = 1;
    end
    check("R1 no deferred start", {31'd0, late}, 32'd0);
    check("R9 rdata held", {16'd0, rdata}, {16'd0, 7'h0C, 9'h0A5});
  endtask

  initial begin
    #(200000 * 4);
    check("watchdog global", 32'd0, 32'd1);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0; req_write = 1'b0; req_index = '0; req_wdata = '0;
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_write_ok();
    t_read_ok();
    t_read_mismatch_recover();
    t_read_exhaust();
    t_write_timeout_all();
    t_write_timeout_some();
    t_write_bad_echo();
    t_read_silent_once();
    t_busy_ignore();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule